// File: doc/BRIEF.md
# I2C Byte Framing and Own-Address Match Unit

This block is the byte-level engine behind a multi-master I2C port. Software writes an 8-bit control word and an own-address register. The block then shifts serial bits in or out on each sampled clock edge that the bus front end reports. After the programmed number of bits it raises a level interrupt. In addressed mode it compares the first byte after a START with the own address, using either 7-bit or 10-bit format, and it recognises a general call. After an address mismatch it stays silent until the next START.

Bytes leave the block on a receive valid/ready stream and enter it on a transmit valid/ready stream. Each stream transfers a byte on a cycle where both valid and ready are high. `rx_valid` stays up while a completed byte waits; taking it clears the interrupt and arms reception of the next byte. `tx_ready` is low while a byte is shifting, in the cycle of a START, while the interface is disabled, and when the unit is neither addressed nor in free-data mode. A producer may therefore hold `tx_valid` high indefinitely.

The serial side is open-drain. The block only asserts pull-low enables, and it routes them to one of two pad pairs. START, STOP and bit-sample pulses come from an external bus front end.

Top module: `i2c_frame_ctl`

## Requirements
- R1: Control bits [2:0] give the bit length of the next transfer: a value k of 1 to 7 means k bits and 000 means 8. `irq` rises in the cycle after the edge that samples the k-th `bit_tick`.
- R2: An accepted START (`start_det` while enabled) clears control bits [2:0] to 000, even when a control write lands in the same cycle, and the other fields take the written value. It also sets `bus_busy`, clears `irq` and starts an 8-bit receive. `stop_det` clears `bus_busy`.
- R3: While control bit 3 (enable) is 0, every `scl_oe_p` and `sda_oe_p` output is 0.
- R4: While disabled, `irq` reads 1 (including out of reset), `bus_busy` reads 0, `tx_ready` and `rx_valid` are 0, and a write offered on the transmit stream starts no transfer.
- R5: When control bit 4 is 0, only the first byte after START is matched. A mismatch raises no interrupt, `addr_hit` stays 0, and `tx_ready` stays 0 until the next START. When bit 4 is 1, every completed byte interrupts and no comparison is made.
- R6: When control bit 5 is 0 (7-bit format), received bits [7:1] are compared with own-address bits [6:0]. Received bit 0 and own-address bits [9:7] are ignored. A match sets `addr_hit` and interrupts.
- R7: When control bit 5 is 1 (10-bit format), a first byte whose bits [7:1] equal 11110 followed by own-address bits [9:8] raises no interrupt and arms a second 8-bit receive. A second byte equal to own-address bits [7:0] sets `addr_hit` and interrupts, and any other second byte is dropped as a mismatch.
- R8: A first byte of 0x00 in addressed mode sets `gen_call` and interrupts in either address format. `addr_hit` stays 0.
- R9: A transmit handshake loads the byte, clears `irq` and shifts it out MSB first. `sda_oe_p` on the routed pair is 1 exactly while the current bit is 0, and a START in the same cycle blocks the handshake.
- R10: `rx_valid` equals enable AND `irq`, and `rx_data` carries the byte received, filled from ones when fewer than 8 bits were shifted. A receive handshake clears `irq`.
- R11: Control bits [7:6] route the pad pair: 01 selects pair 0, 10 selects pair 1, and 00 or 11 select none. Both pairs are never driven together, and serial input is taken only from the routed pair.
- R12: `scl_oe_p` on the routed pair is 1 while the unit is enabled, the bus is busy and `irq` is pending, which holds the clock low until software services the byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 8 | Control word value |
| own_we | input | 1 | Own-address write strobe |
| own_wdata | input | 10 | Own-address value |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmit byte can be taken |
| tx_data | input | 8 | Transmit byte |
| rx_valid | output | 1 | Received byte waiting |
| rx_ready | input | 1 | Consumer takes the received byte |
| rx_data | output | 8 | Received byte |
| start_det | input | 1 | START condition seen (one-cycle pulse) |
| stop_det | input | 1 | STOP condition seen (one-cycle pulse) |
| bit_tick | input | 1 | Serial data sample point (one-cycle pulse) |
| sda_in_p | input | 2 | Data line level of each pad pair |
| scl_oe_p | output | 2 | Clock pull-low enable for each pad pair |
| sda_oe_p | output | 2 | Data pull-low enable for each pad pair |
| irq | output | 1 | Transfer-complete interrupt, level held |
| bus_busy | output | 1 | Bus between START and STOP |
| addr_hit | output | 1 | Own address matched since START |
| gen_call | output | 1 | General call received since START |

## Verification
START can arrive in the same cycle as a control-word write. It can also arrive in the same cycle as a byte offered on the transmit stream. The bench provokes the first case by writing a 3-bit length together with the START pulse. It then judges the outcome by `irq` staying low after seven sampled bits and rising only after the eighth. For the second case it pulses START while `tx_valid` offers 0x00. It checks that `tx_ready` was low in that cycle, that `irq` then clears and `bus_busy` sets, and that the data line stays released, which shows that a ones-filled receive started instead of the zero byte.

// File: rtl/i2cf_pkg.sv
`timescale 1ns/1ps
package i2cf_pkg;
  // Control word, MSB first: route[7:6], ten[5], free[4], en[3], len[2:0]
  typedef struct packed {
    logic [1:0] route;
    logic       ten;
    logic       free;
    logic       en;
    logic [2:0] len;
  } ctrl_t;

  typedef enum logic [1:0] {PH_IDLE, PH_A1, PH_A2, PH_DATA} phase_t;
endpackage

// File: rtl/i2cf_ctrl_reg.sv
`timescale 1ns/1ps
module i2cf_ctrl_reg
  import i2cf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  input  logic       start_i,
  output ctrl_t      ctrl_o
);
  ctrl_t ctrl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else begin
      if (we_i)    ctrl_q     <= ctrl_t'(wdata_i);
      if (start_i) ctrl_q.len <= 3'b000;
    end
  end

  assign ctrl_o = ctrl_q;

  // R2
  len_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (ctrl_q.len == 3'b000));
endmodule

// File: rtl/i2cf_shifter.sv
`timescale 1ns/1ps
module i2cf_shifter #(
  parameter int DW = 8,
  localparam int CW = $clog2(DW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          abort_i,
  input  logic          start_i,
  input  logic          load_i,
  input  logic [DW-1:0] load_data_i,
  input  logic          rearm_i,
  input  logic          tick_i,
  input  logic          sda_i,
  input  logic [CW-1:0] nbits_i,
  output logic          active_o,
  output logic [DW-1:0] shreg_o,
  output logic [DW-1:0] next_byte_o,
  output logic          done_o
);
  logic          active_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] sh_q;

  assign next_byte_o = {sh_q[DW-2:0], sda_i};
  assign done_o      = active_q && tick_i && ((cnt_q + CW'(1)) == nbits_i);

  always_ff @(posedge clk) begin
    if (!rst_n || abort_i) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      sh_q     <= '1;
    end else if (start_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
      sh_q     <= '1;
    end else if (load_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
      sh_q     <= load_data_i;
    end else if (rearm_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
      sh_q     <= '1;
    end else if (active_q && tick_i) begin
      sh_q <= next_byte_o;
      if (done_o) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  assign active_o = active_q;
  assign shreg_o  = sh_q;

  // R9
  load_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !abort_i && !start_i) |=> (active_q && cnt_q == '0 && sh_q == $past(load_data_i)));
endmodule

// File: rtl/i2cf_addr_fsm.sv
`timescale 1ns/1ps
module i2cf_addr_fsm
  import i2cf_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          off_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          done_i,
  input  logic [7:0]    byte_i,
  input  logic          free_i,
  input  logic          ten_i,
  input  logic [AW-1:0] own_i,
  output logic          irq_set_o,
  output logic          rearm_o,
  output logic          xfer_ok_o,
  output logic          hit_o,
  output logic          gc_o
);
  phase_t ph_q, ph_d;
  logic   hit_q, hit_d, gc_q, gc_d;
  logic   is_gc, m7, m10a, m10b;

  assign is_gc = (byte_i == 8'h00);
  assign m7    = (byte_i[7:1] == own_i[6:0]);
  assign m10a  = (byte_i[7:1] == {5'b11110, own_i[AW-1:AW-2]});
  assign m10b  = (byte_i == own_i[7:0]);

  always_comb begin
    ph_d      = ph_q;
    hit_d     = hit_q;
    gc_d      = gc_q;
    irq_set_o = 1'b0;
    rearm_o   = 1'b0;
    if (done_i) begin
      unique case (ph_q)
        PH_A1: begin
          if (free_i) begin
            irq_set_o = 1'b1; ph_d = PH_DATA;
          end else if (is_gc) begin
            gc_d = 1'b1; irq_set_o = 1'b1; ph_d = PH_DATA;
          end else if (!ten_i && m7) begin
            hit_d = 1'b1; irq_set_o = 1'b1; ph_d = PH_DATA;
          end else if (ten_i && m10a) begin
            rearm_o = 1'b1; ph_d = PH_A2;
          end else begin
            ph_d = PH_IDLE;
          end
        end
        PH_A2: begin
          if (m10b) begin
            hit_d = 1'b1; irq_set_o = 1'b1; ph_d = PH_DATA;
          end else begin
            ph_d = PH_IDLE;
          end
        end
        PH_DATA: irq_set_o = 1'b1;
        default: irq_set_o = free_i;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || off_i) begin
      ph_q <= PH_IDLE; hit_q <= 1'b0; gc_q <= 1'b0;
    end else if (start_i) begin
      ph_q <= PH_A1; hit_q <= 1'b0; gc_q <= 1'b0;
    end else if (stop_i) begin
      ph_q <= PH_IDLE;
    end else begin
      ph_q <= ph_d; hit_q <= hit_d; gc_q <= gc_d;
    end
  end

  assign xfer_ok_o = free_i || (ph_q == PH_DATA);
  assign hit_o     = hit_q;
  assign gc_o      = gc_q;

  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_IDLE && !free_i) |-> !irq_set_o);
  // R7
  tenbit_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_A1 && done_i && !free_i && ten_i && byte_i[7:3] != 5'b11110 && byte_i != 8'h00)
      |-> !irq_set_o);
endmodule

// File: rtl/i2c_frame_ctl.sv
`timescale 1ns/1ps
module i2c_frame_ctl
  import i2cf_pkg::*;
#(
  parameter int AW    = 10,
  parameter int NPAIR = 2,
  localparam int DW   = 8,
  localparam int CW   = $clog2(DW + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [7:0]       cfg_wdata,
  input  logic             own_we,
  input  logic [AW-1:0]    own_wdata,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic [DW-1:0]    tx_data,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic [DW-1:0]    rx_data,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic             bit_tick,
  input  logic [NPAIR-1:0] sda_in_p,
  output logic [NPAIR-1:0] scl_oe_p,
  output logic [NPAIR-1:0] sda_oe_p,
  output logic             irq,
  output logic             bus_busy,
  output logic             addr_hit,
  output logic             gen_call
);
  ctrl_t           ctrl;
  logic [AW-1:0]   own_q;
  logic            pend_q, busy_q;
  logic            start_ok, abort, tx_acc, rx_acc;
  logic            active, done, irq_set, fsm_rearm, xfer_ok;
  logic [DW-1:0]   shreg, next_byte;
  logic [CW-1:0]   nbits;
  logic [NPAIR-1:0] sel;
  logic            sda_in, scl_drive, sda_drive;

  assign start_ok = start_det && ctrl.en;
  assign abort    = stop_det || !ctrl.en;
  assign nbits    = (ctrl.len == 3'b000) ? CW'(DW) : CW'(ctrl.len);

  i2cf_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we), .wdata_i(cfg_wdata),
    .start_i(start_ok), .ctrl_o(ctrl)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      own_q <= '0;
    else if (own_we) own_q <= own_wdata;
  end

  assign tx_ready = ctrl.en && !active && !start_det && xfer_ok;
  assign tx_acc   = tx_valid && tx_ready;
  assign rx_valid = ctrl.en && pend_q;
  assign rx_acc   = rx_valid && rx_ready;

  i2cf_shifter #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n), .abort_i(abort), .start_i(start_ok),
    .load_i(tx_acc), .load_data_i(tx_data), .rearm_i(fsm_rearm || rx_acc),
    .tick_i(bit_tick), .sda_i(sda_in), .nbits_i(nbits),
    .active_o(active), .shreg_o(shreg), .next_byte_o(next_byte), .done_o(done)
  );

  i2cf_addr_fsm #(.AW(AW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .off_i(!ctrl.en), .start_i(start_ok),
    .stop_i(stop_det), .done_i(done), .byte_i(next_byte),
    .free_i(ctrl.free), .ten_i(ctrl.ten), .own_i(own_q),
    .irq_set_o(irq_set), .rearm_o(fsm_rearm), .xfer_ok_o(xfer_ok),
    .hit_o(addr_hit), .gc_o(gen_call)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || !ctrl.en) pend_q <= 1'b1;
    else if (start_ok)      pend_q <= 1'b0;
    else if (irq_set)       pend_q <= 1'b1;
    else if (tx_acc || rx_acc) pend_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !ctrl.en) busy_q <= 1'b0;
    else if (start_ok)      busy_q <= 1'b1;
    else if (stop_det)      busy_q <= 1'b0;
  end

  // Pair select: one-hot or none, never both
  always_comb begin
    unique case (ctrl.route)
      2'b01:   sel = NPAIR'(1);
      2'b10:   sel = NPAIR'(2);
      default: sel = '0;
    endcase
  end

  assign sda_in    = (|(sda_in_p & sel)) || !(|sel);
  assign scl_drive = ctrl.en && busy_q && pend_q;
  assign sda_drive = ctrl.en && active && !shreg[DW-1];

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    assign scl_oe_p[p] = sel[p] && scl_drive;
    assign sda_oe_p[p] = sel[p] && sda_drive;
  end

  assign rx_data  = shreg;
  assign irq      = pend_q;
  assign bus_busy = busy_q;

  // R4
  off_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.en |=> (irq && !bus_busy));
  // R11
  pair_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(scl_oe_p | sda_oe_p));
  // R9
  tx_clears_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !irq);
  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && ctrl.en) |=> (bus_busy && !irq));
endmodule

// File: tb/i2c_frame_ctl_tb_top.sv
`timescale 1ns/1ps
module i2c_frame_ctl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic       own_we = 1'b0;
  logic [9:0] own_wdata = '0;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic [7:0] tx_data = '0;
  logic       rx_valid;
  logic       rx_ready = 1'b0;
  logic [7:0] rx_data;
  logic       start_det = 1'b0, stop_det = 1'b0, bit_tick = 1'b0;
  logic [1:0] sda_in_p = 2'b11;
  logic [1:0] scl_oe_p, sda_oe_p;
  logic       irq, bus_busy, addr_hit, gen_call;

  int nchk = 0, nfail = 0, pair_sel = 0;
  logic [7:0] exp_q[$];

  always #2.5 clk = ~clk;

  i2c_frame_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .own_we(own_we), .own_wdata(own_wdata), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .start_det(start_det),
    .stop_det(stop_det), .bit_tick(bit_tick), .sda_in_p(sda_in_p),
    .scl_oe_p(scl_oe_p), .sda_oe_p(sda_oe_p), .irq(irq),
    .bus_busy(bus_busy), .addr_hit(addr_hit), .gen_call(gen_call)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: every receive handshake pops one expected byte
  always @(negedge clk) begin
    if (rst_n && rx_valid && rx_ready) begin
      if (exp_q.size() == 0) chk(1'b0, "R10 unexpected rx byte", rx_data, 0);
      else begin
        automatic logic [7:0] e = exp_q.pop_front();
        chk(rx_data == e, "R10 rx byte", rx_data, e);
      end
    end
  end

  task automatic step(); @(posedge clk); #1; endtask
  task automatic cfg(input logic [7:0] v);
    cfg_we = 1'b1; cfg_wdata = v; step(); cfg_we = 1'b0;
  endtask
  task automatic own(input logic [9:0] v);
    own_we = 1'b1; own_wdata = v; step(); own_we = 1'b0;
  endtask
  task automatic do_start(); start_det = 1'b1; step(); start_det = 1'b0; endtask
  task automatic do_stop();  stop_det  = 1'b1; step(); stop_det  = 1'b0; endtask
  task automatic put_bit(input logic b);
    if (pair_sel == 0) sda_in_p = {~b, b}; else sda_in_p = {b, ~b};
    bit_tick = 1'b1; step(); bit_tick = 1'b0; step();
  endtask
  task automatic send_bits(input logic [7:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) put_bit(v[i]);
  endtask
  task automatic take_rx(input logic [7:0] e);
    exp_q.push_back(e); rx_ready = 1'b1; step(); rx_ready = 1'b0;
  endtask

  initial begin
    #1000000;
    nfail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [7:0] e;
    int mism;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R4 R3 reset state
    chk(irq && !bus_busy && !tx_ready && !rx_valid, "R4 reset flags",
        {irq, bus_busy, tx_ready, rx_valid}, 4'b1000);
    chk(scl_oe_p == 0 && sda_oe_p == 0, "R3 reset pads", {scl_oe_p, sda_oe_p}, 0);

    // R2 START with same-cycle control write of length 3: START wins
    cfg(8'h58);
    cfg_we = 1'b1; cfg_wdata = 8'h5B; start_det = 1'b1; step();
    cfg_we = 1'b0; start_det = 1'b0;
    chk(bus_busy && !irq, "R2 start busy", {bus_busy, irq}, 2'b10);
    send_bits(8'h55 >> 1, 7);
    chk(!irq, "R2 no irq after 7 bits", irq, 0);
    put_bit(1'b1);
    chk(irq, "R2 irq after 8 bits", irq, 1);
    take_rx(8'h55);

    // R1 each length 1..7
    for (int k = 1; k < 8; k++) begin
      cfg(8'h58 | 8'(k));
      if (k > 1) begin
        send_bits(8'hA5 >> 1, k - 1);
        chk(!irq, $sformatf("R1 early len %0d", k), irq, 0);
      end
      put_bit(1'b1);
      chk(irq, $sformatf("R1 irq len %0d", k), irq, 1);
      e = 8'((8'hFF << k) | (8'hA5 & 8'((1 << k) - 1)));
      take_rx(e);
    end
    do_stop();
    chk(!bus_busy, "R2 stop clears busy", bus_busy, 0);

    // R6 7-bit match, own[9:7] ignored
    own(10'h2AA);
    cfg(8'h48);
    do_start();
    send_bits(8'h55, 8);
    chk(irq && addr_hit && !gen_call, "R6 7-bit match", {irq, addr_hit, gen_call}, 3'b110);
    chk(rx_data == 8'h55, "R10 rx addr byte", rx_data, 8'h55);
    chk(scl_oe_p == 2'b01, "R12 clock held", scl_oe_p, 2'b01);

    // R9 transmit 0x96 MSB first
    tx_valid = 1'b1; tx_data = 8'h96;
    @(negedge clk);
    chk(tx_ready, "R9 tx ready", tx_ready, 1);
    step(); tx_valid = 1'b0;
    chk(!irq, "R9 tx clears irq", irq, 0);
    mism = 0;
    for (int i = 7; i >= 0; i--) begin
      if (sda_oe_p != {1'b0, ~tx_data[i]}) mism++;
      put_bit(1'b1);
    end
    chk(mism == 0, "R9 sda drive pattern", mism, 0);
    chk(irq, "R9 irq after tx byte", irq, 1);
    do_stop();

    // R5 mismatch
    do_start();
    send_bits(8'h57, 8);
    chk(!irq && !addr_hit && !tx_ready, "R5 mismatch silent", {irq, addr_hit, tx_ready}, 0);

    // R8 general call
    do_start();
    send_bits(8'h00, 8);
    chk(irq && gen_call && !addr_hit, "R8 general call", {irq, gen_call, addr_hit}, 3'b110);
    take_rx(8'h00);

    // R7 10-bit
    own(10'h2B5);
    cfg(8'h68);
    do_start();
    send_bits(8'hF4, 8);
    chk(!irq, "R7 header no irq", irq, 0);
    send_bits(8'hB5, 8);
    chk(irq && addr_hit, "R7 10-bit match", {irq, addr_hit}, 2'b11);
    take_rx(8'hB5);
    do_start();
    send_bits(8'hF4, 8);
    send_bits(8'hB4, 8);
    chk(!irq && !addr_hit, "R7 10-bit low mismatch", {irq, addr_hit}, 0);
    do_stop();

    // R11 routing to pair 1, input from pair 1 only
    cfg(8'h98);
    pair_sel = 1;
    do_start();
    send_bits(8'hC3, 8);
    chk(irq && scl_oe_p == 2'b10, "R11 pair1 clock", scl_oe_p, 2'b10);
    cfg(8'hD8);
    chk(scl_oe_p == 0 && sda_oe_p == 0, "R11 route 11 none", {scl_oe_p, sda_oe_p}, 0);
    cfg(8'h98);
    take_rx(8'hC3);
    pair_sel = 0;
    do_stop();

    // R4 R3 disable
    cfg(8'h50);
    step();
    chk(irq && !bus_busy && !tx_ready && !rx_valid, "R4 disabled flags",
        {irq, bus_busy, tx_ready, rx_valid}, 4'b1000);
    chk(scl_oe_p == 0 && sda_oe_p == 0, "R3 disabled pads", {scl_oe_p, sda_oe_p}, 0);
    tx_valid = 1'b1; tx_data = 8'h00; step(); step(); tx_valid = 1'b0;
    cfg(8'h58);
    chk(sda_oe_p == 0 && irq, "R4 write ignored", {sda_oe_p, irq}, 3'b001);

    // R9 R2 START together with transmit offer
    tx_valid = 1'b1; tx_data = 8'h00; start_det = 1'b1;
    @(negedge clk);
    chk(!tx_ready, "R9 start blocks tx", tx_ready, 0);
    step(); start_det = 1'b0;
    chk(bus_busy && !irq && sda_oe_p == 0, "R2 start over tx",
        {bus_busy, irq, sda_oe_p}, 4'b1000);
    @(negedge clk);
    chk(!tx_ready, "R9 busy shifting", tx_ready, 0);
    step(); tx_valid = 1'b0;

    chk(exp_q.size() == 0, "R10 scoreboard drained", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule